// File: doc/BRIEF.md
# Event Counter Bank

This block is a small performance monitor made of four independent 32-bit counters behind a 32-bit register port. Each counter has two words. The control word picks one of eight event strobes through a 5-bit identifier in bits [7:3]. The data word holds the running count. Software loads or clears the count by writing the data word, and halts a counter by writing zero to its control word.

A counter adds one on every clock edge at which its selected strobe is high. Identifiers outside the supported set count nothing. The count rolls over from 0xFFFFFFFF to 0 without raising any flag. Reads are combinational: `bus_rdata` always shows the word at `bus_addr`.

Top module: `evt_counter_bank`

## Requirements
- R1: Counter i (i = 0..3) has its control word at byte offset 0xA8 + 8*i and its data word at 0xAC + 8*i. `bus_rdata` shows the addressed word in the same cycle.
- R2: A write to a control word stores all 32 bits, which read back unchanged. A control word changes only when it is written.
- R3: The identifier is control bits [7:3]. Identifiers map to `evt_in` lanes as follows: 0x0D to lane 0, 0x0E to lane 1, 0x0F to lane 2, 0x10 to lane 3, 0x13 to lane 4, 0x14 to lane 5, 0x15 to lane 6 and 0x17 to lane 7. A counter with a supported identifier adds exactly one on each edge at which its lane is high.
- R4: A control word of zero halts its counter, which then holds its value.
- R5: A counter does not count when its identifier is 0x18 or above, a gap value (for example 0x11) or zero with other control bits set.
- R6: A write to a data word loads the written value, so writing 0 clears the count.
- R7: A data write in the same cycle as a qualifying event wins: the count becomes the written value, with no increment added.
- R8: The count wraps from 0xFFFFFFFF to 0 and carries on counting.
- R9: A read of any offset that R1 does not map (including misaligned ones) returns 0. A write to such an offset changes no register.
- R10: After synchronous reset every control and data word reads 0.
- R11: The counters run independently. Writing one counter's words does not change any other counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 12 | Byte offset of the word being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Contents of the addressed word, 0 when unmapped |
| evt_in | input | 8 | Event strobes, one lane per supported identifier |

## Verification
Several rules are checked by assertions on every cycle. A counter never moves by more than one per cycle unless a data write loads it. A halted counter or one with an out-of-range identifier holds its value. A data write lands exactly. Control words change only when written. The address decode selects at most one word, and unmapped reads return zero. Other behaviour needs the bench scenarios and its per-clock reference model. These are the exact lane chosen for each identifier, the gap identifiers inside the supported range, wrap-around of the count, and the isolation of one counter from writes to another.

// File: rtl/evt_bank_pkg.sv
// Package: evt_bank_pkg
// Shared constants and the mapping from event identifier to input lane.
// Assumes eight event lanes and a 5-bit identifier in control bits [7:3].
package evt_bank_pkg;
    localparam int ID_LSB    = 3;
    localparam int ID_W      = 5;
    localparam int NUM_LANES = 8;
    localparam int LANE_W    = $clog2(NUM_LANES);

    typedef struct packed {
        logic              ok;
        logic [LANE_W-1:0] lane;
    } lane_sel_t;

    // Translate an identifier to its lane; unsupported values give ok = 0
    function automatic lane_sel_t id_to_lane(input logic [ID_W-1:0] id);
        lane_sel_t s;
        s.ok   = 1'b1;
        s.lane = '0;
        case (id)
            5'h0D:   s.lane = LANE_W'(0);
            5'h0E:   s.lane = LANE_W'(1);
            5'h0F:   s.lane = LANE_W'(2);
            5'h10:   s.lane = LANE_W'(3);
            5'h13:   s.lane = LANE_W'(4);
            5'h14:   s.lane = LANE_W'(5);
            5'h15:   s.lane = LANE_W'(6);
            5'h17:   s.lane = LANE_W'(7);
            default: s.ok   = 1'b0;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/evt_bank_decode.sv
// Module: evt_bank_decode
// Turns a byte offset into one-hot selects for control and data words.
// Assumes the two words of a counter sit 4 bytes apart and counters repeat every STRIDE bytes.
module evt_bank_decode #(
    parameter int ADDR_W   = 12,
    parameter int NUM_CTR  = 4,
    parameter int CTL_BASE = 'hA8,
    parameter int DAT_OFS  = 4,
    parameter int STRIDE   = 8
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_CTR-1:0] ctl_sel,
    output logic [NUM_CTR-1:0] dat_sel,
    output logic               hit
);
    // One exact-match comparator per word
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_match
        localparam int CTL_ADDR = CTL_BASE + STRIDE * i;
        localparam int DAT_ADDR = CTL_ADDR + DAT_OFS;
        assign ctl_sel[i] = (addr == ADDR_W'(CTL_ADDR));
        assign dat_sel[i] = (addr == ADDR_W'(DAT_ADDR));
    end

    // Any mapped word addressed
    assign hit = |{ctl_sel, dat_sel};
endmodule

// File: rtl/evt_counter_slot.sv
// Module: evt_counter_slot
// One counter with its control word. It adds one per cycle while the lane picked
// by control bits [7:3] is high. A data write loads the count and wins over an increment.
// Assumes the write enables are already decoded and at most one is high.
module evt_counter_slot
    import evt_bank_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_we,
    input  logic                 dat_we,
    input  logic [CNT_W-1:0]     wdata,
    input  logic [NUM_LANES-1:0] evt_in,
    output logic [CNT_W-1:0]     ctl_q,
    output logic [CNT_W-1:0]     cnt_q
);
    logic [ID_W-1:0] id;
    lane_sel_t       sel;
    logic            inc;

    // Decode identifier and qualify the selected strobe
    always_comb begin
        id  = ctl_q[ID_LSB +: ID_W];
        sel = id_to_lane(id);
        inc = (ctl_q != '0) && sel.ok && evt_in[sel.lane];
    end

    // Control word register
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_we) ctl_q <= wdata;
    end

    // Count register: a load has priority over an increment
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (dat_we) cnt_q <= wdata;
        else if (inc)    cnt_q <= cnt_q + 1'b1;
    end

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_we |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
    // R4
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q == '0 && !dat_we) |=> $stable(cnt_q));
    // R5
    badid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[7:3] >= 5'h18 && !dat_we) |=> $stable(cnt_q));
    // R7
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_we |=> (cnt_q == $past(wdata)));
    // R2
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> $stable(ctl_q));
endmodule

// File: rtl/evt_counter_bank.sv
// Module: evt_counter_bank
// Top of the counter bank: address decode, NUM_CTR counter slots and a read mux.
// Assumes a single-cycle register port with combinational read data.
module evt_counter_bank
    import evt_bank_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int NUM_CTR  = 4,
    parameter int CTL_BASE = 'hA8,
    parameter int STRIDE   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_LANES-1:0] evt_in
);
    localparam int DAT_OFS = DATA_W / 8;

    logic [NUM_CTR-1:0] ctl_sel, dat_sel;
    logic               hit;
    logic [DATA_W-1:0]  ctl_q [NUM_CTR];
    logic [DATA_W-1:0]  cnt_q [NUM_CTR];

    evt_bank_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_CTR (NUM_CTR),
        .CTL_BASE(CTL_BASE),
        .DAT_OFS (DAT_OFS),
        .STRIDE  (STRIDE)
    ) u_decode (
        .addr   (bus_addr),
        .ctl_sel(ctl_sel),
        .dat_sel(dat_sel),
        .hit    (hit)
    );

    // One counter slot per index
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
        evt_counter_slot #(.CNT_W(DATA_W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl_we(bus_we & ctl_sel[i]),
            .dat_we(bus_we & dat_sel[i]),
            .wdata (bus_wdata),
            .evt_in(evt_in),
            .ctl_q (ctl_q[i]),
            .cnt_q (cnt_q[i])
        );
    end

    // Read mux: zero unless a mapped word is addressed
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (ctl_sel[i]) bus_rdata = ctl_q[i];
            if (dat_sel[i]) bus_rdata = cnt_q[i];
        end
    end

    // R1
    onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_sel, dat_sel}));
    // R9
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (bus_rdata == '0));
endmodule

// File: tb/evt_counter_bank_tb.sv
module evt_counter_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  evt_in = '0;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    logic [31:0] mctl [4];
    logic [31:0] mcnt [4];

    always #2 clk = ~clk;

    evt_counter_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in)
    );

    function automatic int lane_of(logic [4:0] id);
        case (id)
            5'h0D: return 0;  5'h0E: return 1;  5'h0F: return 2;  5'h10: return 3;
            5'h13: return 4;  5'h14: return 5;  5'h15: return 6;  5'h17: return 7;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] mread(logic [11:0] a);
        for (int i = 0; i < 4; i++) begin
            if (a == 12'(168 + 8 * i)) return mctl[i];
            if (a == 12'(172 + 8 * i)) return mcnt[i];
        end
        return 32'h0;
    endfunction

    // Reference model, advanced on each rising edge
    always @(posedge clk) begin
        for (int i = 0; i < 4; i++) begin
            int  ln;
            bit  inc;
            ln  = lane_of(mctl[i][7:3]);
            inc = (mctl[i] != 0) && (ln >= 0) && evt_in[ln];
            if (!rst_n) begin
                mctl[i] = 0; mcnt[i] = 0;
            end else begin
                if (bus_we && bus_addr == 12'(172 + 8 * i)) mcnt[i] = bus_wdata;
                else if (inc) mcnt[i] = mcnt[i] + 1;
                if (bus_we && bus_addr == 12'(168 + 8 * i)) mctl[i] = bus_wdata;
            end
        end
    end

    // R1: compare the addressed word with the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (bus_rdata !== mread(bus_addr)) begin
                errors++;
                $display("FAIL R1 model addr=%h actual=%h expected=%h", bus_addr, bus_rdata, mread(bus_addr));
            end
        end
    end

    task automatic cyc(input bit we, input logic [11:0] a, input logic [31:0] d, input logic [7:0] e);
        bus_we = we; bus_addr = a; bus_wdata = d; evt_in = e;
        @(posedge clk); #1;
        bus_we = 0; evt_in = 0;
    endtask

    task automatic chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        bus_we = 0; bus_addr = a; evt_in = 0;
        @(negedge clk);
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        rst_n = 1;
        // R10 reset state
        for (int i = 0; i < 4; i++) begin
            chk(12'(168 + 8 * i), 0, "R10 ctl");
            chk(12'(172 + 8 * i), 0, "R10 cnt");
        end
        // R2 control programming
        cyc(1, 12'hA8, 32'h68, 0);
        cyc(1, 12'hB0, 32'hB8, 0);
        cyc(1, 12'hB8, 32'h80, 0);
        cyc(1, 12'hC0, 32'hC0, 0);
        chk(12'hA8, 32'h68, "R2");
        chk(12'hB0, 32'hB8, "R2");
        // R3 all lanes high, R5 id 0x18
        repeat (5) cyc(0, 12'h0, 0, 8'hFF);
        chk(12'hAC, 5, "R3");
        chk(12'hB4, 5, "R3");
        chk(12'hBC, 5, "R3");
        chk(12'hC4, 0, "R5");
        // R3 lane 0 only, R11 others hold
        repeat (3) cyc(0, 12'h0, 0, 8'h01);
        chk(12'hAC, 8, "R3");
        chk(12'hB4, 5, "R11");
        // R4 halt counter 0
        cyc(1, 12'hA8, 0, 0);
        repeat (4) cyc(0, 12'h0, 0, 8'hFF);
        chk(12'hAC, 8, "R4");
        chk(12'hB4, 9, "R3");
        // R6 clear during events
        cyc(1, 12'hB4, 0, 8'hFF);
        chk(12'hB4, 0, "R6");
        chk(12'hBC, 10, "R11");
        // R8 wrap
        cyc(1, 12'hBC, 32'hFFFF_FFFE, 0);
        repeat (3) cyc(0, 12'h0, 0, 8'h08);
        chk(12'hBC, 1, "R8");
        chk(12'hB8, 32'h80, "R2");
        // R9 unmapped
        cyc(1, 12'hA4, 32'hFFFF_FFFF, 0);
        cyc(1, 12'hC8, 32'hFFFF_FFFF, 0);
        cyc(1, 12'hAA, 32'hFFFF_FFFF, 0);
        cyc(1, 12'h000, 32'hFFFF_FFFF, 0);
        chk(12'hA4, 0, "R9");
        chk(12'hC8, 0, "R9");
        chk(12'hAA, 0, "R9");
        chk(12'hAC, 8, "R9");
        chk(12'hB4, 0, "R9");
        chk(12'hBC, 1, "R9");
        chk(12'hA8, 0, "R9");
        // R5 gap id 0x11 and zero id with other bits
        cyc(1, 12'hA8, 32'h88, 0);
        cyc(1, 12'hC0, 32'h01, 0);
        repeat (2) cyc(0, 12'h0, 0, 8'hFF);
        chk(12'hAC, 8, "R5");
        chk(12'hC4, 0, "R5");
        // R7 load beats increment
        cyc(1, 12'hA8, 32'h68, 0);
        cyc(1, 12'hAC, 32'h1234, 8'hFF);
        chk(12'hAC, 32'h1234, "R7");
        cyc(0, 12'h0, 0, 8'h01);
        chk(12'hAC, 32'h1235, "R7");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule